// File: doc/BRIEF.md
# Receive Descriptor Ring Engine with Interrupt Ring

This block takes an incoming byte stream, framed by start and end markers and tagged with a channel identifier, and stores each frame into host buffers. It walks a ring of receive descriptors, one buffer per descriptor. When a frame is longer than one buffer it continues in the next descriptor. Each descriptor it fills is handed back to the host with a status word: byte count, end-of-frame flag, management flag and a three-bit frame-type code. The engine only uses a descriptor after the host has given it back.

Completed data frames are reported in two ways. A one-cycle interrupt pulse is raised, and an entry is written into a separate interrupt ring. That entry carries a service bit, the context index of the channel and the index of the frame's first descriptor. The host frees the slot by acknowledging it.

Frames on the management channel use a separate event output instead. They never touch the interrupt ring or the interrupt line. Frames that find no owned descriptor are dropped and counted.

Top module: `rxr_engine`

## Requirements
- R1: A frame whose start beat arrives while `ch_active` or `ch_rx_ready` is low is discarded entirely. It causes no buffer, descriptor, interrupt-ring, interrupt or event output, and `miss_cnt` stays unchanged.
- R2: Byte k of an accepted frame is written with `buf_we` at `buf_addr = {descriptor index, offset}`. The offset is k modulo BUF_BYTES. The write appears in the cycle after the byte is accepted.
- R3: A frame longer than BUF_BYTES continues in the next descriptor index, modulo NDESC. Each buffer that fills up completely gets a descriptor write with count BUF_BYTES and end-of-frame 0. The frame's last descriptor gets end-of-frame 1 and the count of bytes in it.
- R4: The descriptor status word is 16 bits wide. Bit 15 is ownership, written as 0 to hand the descriptor to the host. Bit 14 is end-of-frame, bit 13 is management, bit 12 is 0, bits 11:9 hold the frame-type code and bits 8:0 hold the byte count.
- R5: The engine fills only descriptors whose ownership flag has been set through `own_give`. Writing a descriptor clears that flag, so the descriptor is used again only after another `own_give`.
- R6: A completed data frame pulses `rx_irq` for one cycle, in the same cycle as its end-of-frame descriptor write. It also writes an interrupt-ring entry of the form {service bit = 1 (MSB), `ctx_index`, first descriptor index (LSBs)}.
- R7: A frame whose `rx_chan` equals MGMT_CHAN is a management frame. It produces no `rx_irq` and no interrupt-ring write. Instead it pulses `mgmt_evt`, with `mgmt_type` set to the `rx_ftype` sampled at its start beat. Its descriptors carry bit 13 = 1 and that code in bits 11:9; data frames carry 0 and 000 there.
- R8: A frame that starts while the channel is enabled but the current descriptor is not owned is dropped. `miss_cnt` increases by one, and its remaining bytes up to the end beat are ignored.
- R9: If a frame fills a buffer and then finds the next descriptor not owned, the descriptors already written stay with end-of-frame 0. The rest of the frame is dropped, `miss_cnt` increases by one, and no `rx_irq` is raised.
- R10: Interrupt-ring slots are used in order, modulo IRING. A slot stays busy from its write until `irng_ack` names it. A data frame that completes while the next slot is busy still pulses `rx_irq`, but writes no entry and does not advance the slot pointer. In that case `irng_ovf` sets and stays set until reset.
- R11: After reset all write strobes, pulses, `irng_ovf` and `miss_cnt` are zero. No descriptor is owned, all ring slots are free, and both the descriptor and ring pointers are at index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_active | input | 1 | Channel active enable |
| ch_rx_ready | input | 1 | Channel receive-ready enable |
| ctx_index | input | CTX_W | Context table index reported in ring entries |
| rx_valid | input | 1 | Byte valid |
| rx_sof | input | 1 | First byte of frame |
| rx_eof | input | 1 | Last byte of frame |
| rx_data | input | 8 | Frame byte |
| rx_chan | input | CHAN_W | Channel identifier of the frame |
| rx_ftype | input | 3 | Frame-type code for management frames |
| own_give | input | 1 | Host returns a descriptor to the engine |
| own_give_idx | input | log2(NDESC) | Index of the returned descriptor |
| irng_ack | input | 1 | Host frees an interrupt-ring slot |
| irng_ack_idx | input | log2(IRING) | Slot being freed |
| buf_we | output | 1 | Buffer byte write strobe |
| buf_addr | output | log2(NDESC)+log2(BUF_BYTES) | Buffer byte address |
| buf_data | output | 8 | Buffer byte |
| desc_we | output | 1 | Descriptor status write strobe |
| desc_idx | output | log2(NDESC) | Descriptor being written |
| desc_word | output | 16 | Descriptor status word |
| irng_we | output | 1 | Interrupt-ring entry write strobe |
| irng_idx | output | log2(IRING) | Slot being written |
| irng_entry | output | 1+CTX_W+log2(NDESC) | Interrupt-ring entry |
| rx_irq | output | 1 | Data-frame receive interrupt pulse |
| mgmt_evt | output | 1 | Management-frame event pulse |
| mgmt_type | output | 3 | Type code of the management frame |
| irng_ovf | output | 1 | Sticky interrupt-ring overflow |
| miss_cnt | output | MISS_W | Missed-frame counter |

## Verification
The checker watches several properties on every cycle. An interrupt always comes with an end-of-frame data descriptor write, and a ring write always comes with an interrupt. Management events never coincide with interrupts or ring writes. A descriptor closed without end-of-frame always sits on the buffer's last byte. The overflow flag never falls, and the missed-frame counter only ever steps by one.

Some behaviour can only be shown by the directed scenarios. These cover where bytes land across chained buffers and the exact status and entry values. They also cover dropping on a disabled channel, dropping with no owned descriptor and starvation in mid-frame. The remaining scenarios cover reuse that needs a fresh give, ring wrap into a busy slot, and recovery after an acknowledge.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_DROP = 2'd2
    } rx_state_e;

    // Status word: [15] own (0 = host), [14] eof, [13] mgmt, [12] 0,
    // [11:9] type code, [8:0] byte count.
    function automatic logic [15:0] pack_status(input logic eof,
                                                input logic mgmt,
                                                input logic [2:0] ftype,
                                                input logic [8:0] count);
        return {1'b0, eof, mgmt, 1'b0, ftype, count};
    endfunction

endpackage

// File: rtl/rxr_flagset.sv
module rxr_flagset #(
    parameter int N = 8,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_en,
    input  logic [IW-1:0] set_idx,
    input  logic          clr_en,
    input  logic [IW-1:0] clr_idx,
    output logic [N-1:0]  flags
);

    logic [N-1:0] flags_d, flags_q;

    always_comb begin
        flags_d = flags_q;
        if (clr_en) flags_d[clr_idx] = 1'b0;
        if (set_en) flags_d[set_idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flags = flags_q;

endmodule

// File: rtl/rxr_irq_ring.sv
module rxr_irq_ring #(
    parameter int DEPTH = 4,
    localparam int IW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          post,
    input  logic          ack_en,
    input  logic [IW-1:0] ack_idx,
    output logic [IW-1:0] wr_ptr,
    output logic          slot_busy,
    output logic          ovf
);

    typedef struct packed {
        logic [IW-1:0] ptr;
        logic          ovf;
    } ring_s;

    ring_s        r_d, r_q;
    logic [DEPTH-1:0] busy;
    logic         take_slot;

    assign slot_busy = busy[r_q.ptr];
    assign take_slot = post && !slot_busy;

    rxr_flagset #(.N(DEPTH)) u_busy (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (take_slot),
        .set_idx (r_q.ptr),
        .clr_en  (ack_en),
        .clr_idx (ack_idx),
        .flags   (busy)
    );

    always_comb begin
        r_d = r_q;
        if (take_slot)          r_d.ptr = IW'(r_q.ptr + 1'b1);
        if (post && slot_busy)  r_d.ovf = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign wr_ptr = r_q.ptr;
    assign ovf    = r_q.ovf;

endmodule

// File: rtl/rxr_engine.sv
// NDESC, BUF_BYTES and IRING must be powers of two; BUF_BYTES <= 256.
module rxr_engine #(
    parameter int NDESC     = 8,
    parameter int BUF_BYTES = 16,
    parameter int IRING     = 4,
    parameter int CHAN_W    = 10,
    parameter int CTX_W     = 8,
    parameter int MGMT_CHAN = 0,
    parameter int MISS_W    = 8,
    localparam int DIDX_W   = $clog2(NDESC),
    localparam int OFF_W    = $clog2(BUF_BYTES),
    localparam int IR_W     = $clog2(IRING),
    localparam int IENT_W   = 1 + CTX_W + DIDX_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ch_active,
    input  logic                    ch_rx_ready,
    input  logic [CTX_W-1:0]        ctx_index,
    input  logic                    rx_valid,
    input  logic                    rx_sof,
    input  logic                    rx_eof,
    input  logic [7:0]              rx_data,
    input  logic [CHAN_W-1:0]       rx_chan,
    input  logic [2:0]              rx_ftype,
    input  logic                    own_give,
    input  logic [DIDX_W-1:0]       own_give_idx,
    input  logic                    irng_ack,
    input  logic [IR_W-1:0]         irng_ack_idx,
    output logic                    buf_we,
    output logic [DIDX_W+OFF_W-1:0] buf_addr,
    output logic [7:0]              buf_data,
    output logic                    desc_we,
    output logic [DIDX_W-1:0]       desc_idx,
    output logic [15:0]             desc_word,
    output logic                    irng_we,
    output logic [IR_W-1:0]         irng_idx,
    output logic [IENT_W-1:0]       irng_entry,
    output logic                    rx_irq,
    output logic                    mgmt_evt,
    output logic [2:0]              mgmt_type,
    output logic                    irng_ovf,
    output logic [MISS_W-1:0]       miss_cnt
);
    import rxr_pkg::*;

    localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(BUF_BYTES - 1);

    typedef struct packed {
        rx_state_e               st;
        logic [DIDX_W-1:0]       cur;
        logic [DIDX_W-1:0]       first;
        logic [OFF_W-1:0]        off;
        logic                    mgmt;
        logic [2:0]              ftype;
        logic [MISS_W-1:0]       miss;
        logic                    buf_we;
        logic [DIDX_W+OFF_W-1:0] buf_addr;
        logic [7:0]              buf_data;
        logic                    desc_we;
        logic [DIDX_W-1:0]       desc_idx;
        logic [15:0]             desc_word;
        logic                    irng_we;
        logic [IR_W-1:0]         irng_idx;
        logic [IENT_W-1:0]       irng_entry;
        logic                    irq;
        logic                    mevt;
        logic [2:0]              mtype;
    } eng_s;

    eng_s              s_d, s_q;
    logic [NDESC-1:0]  own_flags;
    logic              own_clr;
    logic              post;
    logic [IR_W-1:0]   ring_ptr;
    logic              ring_busy;
    logic              ring_ovf;

    rxr_flagset #(.N(NDESC)) u_own (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (own_give),
        .set_idx (own_give_idx),
        .clr_en  (own_clr),
        .clr_idx (s_q.cur),
        .flags   (own_flags)
    );

    rxr_irq_ring #(.DEPTH(IRING)) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .post      (post),
        .ack_en    (irng_ack),
        .ack_idx   (irng_ack_idx),
        .wr_ptr    (ring_ptr),
        .slot_busy (ring_busy),
        .ovf       (ring_ovf)
    );

    always_comb begin
        logic              take;
        logic              frm_mgmt;
        logic [2:0]        frm_ft;
        logic [DIDX_W-1:0] frm_first;
        logic [OFF_W-1:0]  off_now;

        s_d         = s_q;
        s_d.buf_we  = 1'b0;
        s_d.desc_we = 1'b0;
        s_d.irng_we = 1'b0;
        s_d.irq     = 1'b0;
        s_d.mevt    = 1'b0;
        own_clr     = 1'b0;
        post        = 1'b0;
        take        = 1'b0;
        frm_mgmt    = s_q.mgmt;
        frm_ft      = s_q.ftype;
        frm_first   = s_q.first;
        off_now     = s_q.off;

        case (s_q.st)
            ST_IDLE: begin
                if (rx_valid && rx_sof) begin
                    if (!(ch_active && ch_rx_ready)) begin
                        s_d.st = rx_eof ? ST_IDLE : ST_DROP;
                    end else if (!own_flags[s_q.cur]) begin
                        s_d.miss = s_q.miss + 1'b1;
                        s_d.st   = rx_eof ? ST_IDLE : ST_DROP;
                    end else begin
                        take      = 1'b1;
                        frm_mgmt  = (rx_chan == CHAN_W'(MGMT_CHAN));
                        frm_ft    = frm_mgmt ? rx_ftype : 3'b000;
                        frm_first = s_q.cur;
                        off_now   = '0;
                        s_d.mgmt  = frm_mgmt;
                        s_d.ftype = frm_ft;
                        s_d.first = s_q.cur;
                    end
                end
            end
            ST_FILL: begin
                if (rx_valid) begin
                    if (!own_flags[s_q.cur]) begin
                        s_d.miss = s_q.miss + 1'b1;
                        s_d.st   = rx_eof ? ST_IDLE : ST_DROP;
                    end else begin
                        take = 1'b1;
                    end
                end
            end
            ST_DROP: begin
                if (rx_valid && rx_eof) s_d.st = ST_IDLE;
            end
            default: s_d.st = ST_IDLE;
        endcase

        if (take) begin
            s_d.buf_we   = 1'b1;
            s_d.buf_addr = {s_q.cur, off_now};
            s_d.buf_data = rx_data;
            if (rx_eof || off_now == LAST_OFF) begin
                s_d.desc_we   = 1'b1;
                s_d.desc_idx  = s_q.cur;
                s_d.desc_word = pack_status(rx_eof, frm_mgmt, frm_ft,
                                            9'(off_now) + 9'd1);
                own_clr       = 1'b1;
                s_d.cur       = DIDX_W'(s_q.cur + 1'b1);
                s_d.off       = '0;
            end else begin
                s_d.off = OFF_W'(off_now + 1'b1);
            end
            if (rx_eof) begin
                s_d.st = ST_IDLE;
                if (frm_mgmt) begin
                    s_d.mevt  = 1'b1;
                    s_d.mtype = frm_ft;
                end else begin
                    s_d.irq = 1'b1;
                    post    = 1'b1;
                    if (!ring_busy) begin
                        s_d.irng_we    = 1'b1;
                        s_d.irng_idx   = ring_ptr;
                        s_d.irng_entry = {1'b1, ctx_index, frm_first};
                    end
                end
            end else begin
                s_d.st = ST_FILL;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign buf_we     = s_q.buf_we;
    assign buf_addr   = s_q.buf_addr;
    assign buf_data   = s_q.buf_data;
    assign desc_we    = s_q.desc_we;
    assign desc_idx   = s_q.desc_idx;
    assign desc_word  = s_q.desc_word;
    assign irng_we    = s_q.irng_we;
    assign irng_idx   = s_q.irng_idx;
    assign irng_entry = s_q.irng_entry;
    assign rx_irq     = s_q.irq;
    assign mgmt_evt   = s_q.mevt;
    assign mgmt_type  = s_q.mtype;
    assign irng_ovf   = ring_ovf;
    assign miss_cnt   = s_q.miss;

endmodule

// File: rtl/rxr_engine_chk.sv
module rxr_engine_chk #(
    parameter int NDESC     = 8,
    parameter int BUF_BYTES = 16,
    parameter int MISS_W    = 8,
    localparam int DIDX_W   = $clog2(NDESC),
    localparam int OFF_W    = $clog2(BUF_BYTES)
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    buf_we,
    input logic [DIDX_W+OFF_W-1:0] buf_addr,
    input logic                    desc_we,
    input logic [DIDX_W-1:0]       desc_idx,
    input logic [15:0]             desc_word,
    input logic                    irng_we,
    input logic                    rx_irq,
    input logic                    mgmt_evt,
    input logic                    irng_ovf,
    input logic [MISS_W-1:0]       miss_cnt
);

    // R6
    irq_with_eof_desc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> (desc_we && desc_word[14] && !desc_word[13]));

    // R6
    ring_write_needs_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irng_we |-> rx_irq);

    // R7
    mgmt_stays_off_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mgmt_evt |-> (!rx_irq && !irng_we && desc_we && desc_word[13]));

    // R3
    full_buffer_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_we && !desc_word[14]) |->
            (buf_we && buf_addr == {desc_idx, {OFF_W{1'b1}}}));

    // R10
    overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irng_ovf |=> irng_ovf);

    // R8
    miss_single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(miss_cnt) |-> (miss_cnt == $past(miss_cnt) + 1'b1));

endmodule

bind rxr_engine rxr_engine_chk #(
    .NDESC     (NDESC),
    .BUF_BYTES (BUF_BYTES),
    .MISS_W    (MISS_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .buf_we    (buf_we),
    .buf_addr  (buf_addr),
    .desc_we   (desc_we),
    .desc_idx  (desc_idx),
    .desc_word (desc_word),
    .irng_we   (irng_we),
    .rx_irq    (rx_irq),
    .mgmt_evt  (mgmt_evt),
    .irng_ovf  (irng_ovf),
    .miss_cnt  (miss_cnt)
);

// File: tb/rxr_engine_test.sv
`timescale 1ns/1ps
module rxr_engine_test;

    localparam int NDESC = 8;
    localparam int BUFB  = 16;
    localparam int IRING = 4;
    localparam int CHW   = 10;
    localparam int CTXW  = 8;
    localparam int DIW   = 3;
    localparam int IRW   = 2;
    localparam int IEW   = 1 + CTXW + DIW;
    localparam logic [CTXW-1:0] CTX = 8'h5A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ch_active = 1'b1, ch_rx_ready = 1'b1;
    logic rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
    logic [7:0] rx_data = '0;
    logic [CHW-1:0] rx_chan = '0;
    logic [2:0] rx_ftype = '0;
    logic own_give = 1'b0;
    logic [DIW-1:0] own_give_idx = '0;
    logic irng_ack = 1'b0;
    logic [IRW-1:0] irng_ack_idx = '0;

    logic buf_we, desc_we, irng_we, rx_irq, mgmt_evt, irng_ovf;
    logic [DIW+3:0] buf_addr;
    logic [7:0] buf_data;
    logic [DIW-1:0] desc_idx;
    logic [15:0] desc_word;
    logic [IRW-1:0] irng_idx;
    logic [IEW-1:0] irng_entry;
    logic [2:0] mgmt_type;
    logic [7:0] miss_cnt;

    always #2.5 clk = ~clk;

    rxr_engine uut (
        .clk(clk), .rst_n(rst_n), .ch_active(ch_active), .ch_rx_ready(ch_rx_ready),
        .ctx_index(CTX), .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof),
        .rx_data(rx_data), .rx_chan(rx_chan), .rx_ftype(rx_ftype),
        .own_give(own_give), .own_give_idx(own_give_idx),
        .irng_ack(irng_ack), .irng_ack_idx(irng_ack_idx),
        .buf_we(buf_we), .buf_addr(buf_addr), .buf_data(buf_data),
        .desc_we(desc_we), .desc_idx(desc_idx), .desc_word(desc_word),
        .irng_we(irng_we), .irng_idx(irng_idx), .irng_entry(irng_entry),
        .rx_irq(rx_irq), .mgmt_evt(mgmt_evt), .mgmt_type(mgmt_type),
        .irng_ovf(irng_ovf), .miss_cnt(miss_cnt)
    );

    int n_checks = 0, n_fail = 0;
    logic [7:0]  mem [NDESC*BUFB];
    logic [15:0] dw  [NDESC];
    logic [IEW-1:0] ie [IRING];
    int bcount, dcount, irq_n, mevt_n, irng_n, last_ir;
    logic [2:0] last_mtype;

    // Host-side mirror of everything the block writes.
    always @(negedge clk) begin
        if (rst_n) begin
            if (buf_we)  begin mem[buf_addr] = buf_data; bcount++; end
            if (desc_we) begin dw[desc_idx] = desc_word; dcount++; end
            if (irng_we) begin ie[irng_idx] = irng_entry; irng_n++; last_ir = irng_idx; end
            if (rx_irq)  irq_n++;
            if (mgmt_evt) begin mevt_n++; last_mtype = mgmt_type; end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int st_word(int eof, int mg, int ft, int cnt);
        return (eof << 14) | (mg << 13) | (ft << 9) | cnt;
    endfunction

    function automatic int ent(int d);
        return (1 << (CTXW + DIW)) | (int'(CTX) << DIW) | d;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        bcount = 0; dcount = 0; irq_n = 0; mevt_n = 0; irng_n = 0; last_ir = 0;
        last_mtype = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic give(input int idx);
        @(negedge clk); own_give = 1'b1; own_give_idx = DIW'(idx);
        @(negedge clk); own_give = 1'b0;
    endtask

    task automatic ack(input int idx);
        @(negedge clk); irng_ack = 1'b1; irng_ack_idx = IRW'(idx);
        @(negedge clk); irng_ack = 1'b0;
    endtask

    task automatic send(input int chan, input int len, input int ft, input int base);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_sof = (i == 0); rx_eof = (i == len - 1);
            rx_data = 8'(base + i); rx_chan = CHW'(chan); rx_ftype = 3'(ft);
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        @(negedge clk);
        chk("R11 buf_we", int'(buf_we), 0);
        chk("R11 desc_we", int'(desc_we), 0);
        chk("R11 irq", int'(rx_irq), 0);
        chk("R11 ovf", int'(irng_ovf), 0);
        chk("R11 miss", int'(miss_cnt), 0);
    endtask

    task automatic t_no_owned();
        send(5, 3, 0, 8'h01);
        chk("R8 miss after unowned", int'(miss_cnt), 1);
        chk("R8 no buffer writes", bcount, 0);
        chk("R8 no descriptor writes", dcount, 0);
        send(5, 1, 0, 8'h02);
        chk("R8 miss second", int'(miss_cnt), 2);
    endtask

    task automatic t_disabled();
        give(0);
        ch_active = 1'b0;
        send(5, 4, 0, 8'h20);
        ch_active = 1'b1; ch_rx_ready = 1'b0;
        send(5, 2, 0, 8'h30);
        ch_rx_ready = 1'b1;
        chk("R1 no buffer writes", bcount, 0);
        chk("R1 no descriptor writes", dcount, 0);
        chk("R1 no irq", irq_n, 0);
        chk("R1 miss unchanged", int'(miss_cnt), 2);
    endtask

    task automatic t_single();
        for (int d = 1; d < NDESC; d++) give(d);
        send(5, 5, 0, 8'h10);
        chk("R4 status desc0", int'(dw[0]), st_word(1, 0, 0, 5));
        chk("R2 byte0", int'(mem[0]), 8'h10);
        chk("R2 byte4", int'(mem[4]), 8'h14);
        chk("R6 irq count", irq_n, 1);
        chk("R6 ring entry slot0", int'(ie[0]), ent(0));
    endtask

    task automatic t_chained();
        send(5, 20, 0, 8'h40);
        chk("R3 first buffer status", int'(dw[1]), st_word(0, 0, 0, 16));
        chk("R3 last buffer status", int'(dw[2]), st_word(1, 0, 0, 4));
        chk("R3 byte15", int'(mem[1*BUFB + 15]), 8'h4F);
        chk("R3 byte19", int'(mem[2*BUFB + 3]), 8'h53);
        chk("R6 entry first descriptor", int'(ie[1]), ent(1));
        chk("R6 irq count chained", irq_n, 2);
    endtask

    task automatic t_mgmt();
        send(0, 2, 5, 8'h60);
        chk("R7 mgmt status", int'(dw[3]), st_word(1, 1, 5, 2));
        chk("R7 no irq", irq_n, 2);
        chk("R7 no ring write", irng_n, 2);
        chk("R7 event", mevt_n, 1);
        chk("R7 type", int'(last_mtype), 5);
        send(0, 2, 0, 8'h70);
        chk("R7 type 000 status", int'(dw[4]), st_word(1, 1, 0, 2));
        chk("R7 second event", mevt_n, 2);
    endtask

    task automatic t_wrap_overflow();
        send(5, 1, 0, 8'h80);
        send(5, 1, 0, 8'h81);
        chk("R10 slot2", int'(ie[2]), ent(5));
        chk("R10 slot3", int'(ie[3]), ent(6));
        chk("R10 no ovf yet", int'(irng_ovf), 0);
        send(5, 1, 0, 8'h82);
        chk("R10 ovf raised", int'(irng_ovf), 1);
        chk("R10 irq still pulses", irq_n, 5);
        chk("R10 no entry written", irng_n, 4);
        chk("R10 slot0 kept", int'(ie[0]), ent(0));
        send(5, 1, 0, 8'h83);
        chk("R5 reuse needs give: miss", int'(miss_cnt), 3);
        chk("R5 reuse needs give: no desc", dcount, 8);
        ack(0);
        give(0);
        send(5, 3, 0, 8'h90);
        chk("R5 desc0 refilled", int'(dw[0]), st_word(1, 0, 0, 3));
        chk("R10 entry after ack", irng_n, 5);
        chk("R10 entry in slot0", last_ir, 0);
        chk("R10 ovf sticky", int'(irng_ovf), 1);
    endtask

    task automatic t_starve();
        do_reset();
        chk("R11 ovf cleared", int'(irng_ovf), 0);
        give(0);
        send(5, 20, 0, 8'hA0);
        chk("R9 partial status", int'(dw[0]), st_word(0, 0, 0, 16));
        chk("R9 one descriptor", dcount, 1);
        chk("R9 sixteen bytes", bcount, 16);
        chk("R9 miss", int'(miss_cnt), 1);
        chk("R9 no irq", irq_n, 0);
    endtask

    initial begin
        t_reset();
        t_no_owned();
        t_disabled();
        t_single();
        t_chained();
        t_mgmt();
        t_wrap_overflow();
        t_starve();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule